// File: doc/BRIEF.md
# Configurable-Format Asynchronous Serial Transmitter

This block turns bytes into an asynchronous serial line. Its frame shape is set at run time by a 7-bit line configuration input. That input selects the word length (5 to 8 bits), whether a parity bit is sent, the kind of parity (computed odd or even, or forced to a fixed level), the stop length, and a break override that holds the line low. Bit timing comes from an external `baud_tick` strobe that pulses once per sample period, at 16 times the bit rate. Each line bit lasts 16 of these ticks.

Bytes enter through a valid/ready stream port that feeds a one-entry holding register. `in_ready` is high exactly when the holding register is empty. The producer may raise `in_valid` at any time and must hold `in_valid` and `in_data` steady until it sees `in_ready` high at a clock edge. That edge completes the transfer. The holding register passes its byte to the shift stage on the next edge at which the shift stage is idle or is finishing its last stop tick. While a frame is being sent, a second byte can therefore wait in the holding register. `in_ready` doubles as the holding-empty status, and `tx_empty` reports that both stages are empty.

The format bits 5:0 are captured when a byte moves into the shift stage, so a configuration change takes effect from the next frame. The break bit acts on the output at once.

Top module: `framed_serial_tx`

## Requirements
- R1: After reset, `txd` is 1 (mark), `in_ready` is 1 and `tx_empty` is 1.
- R2: A byte is taken at a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 while the holding register is occupied. `in_ready` returns to 1 on the edge that moves the byte into the shift stage, even though that frame is still being sent.
- R3: A frame starts on the clock edge after the byte is taken, provided the shift stage is idle. It begins with a start bit of 0, followed by the data bits with bit 0 first. Every bit lasts 16 baud ticks. `line_cfg[1:0]` selects the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R4: When `line_cfg[3]` is 0, the stop period follows the last data bit directly. No parity bit is sent, whatever `line_cfg[5:4]` hold.
- R5: When `line_cfg[3]` is 1 and `line_cfg[5]` is 0, a parity bit follows the data. With `line_cfg[4]` = 0 the data bits and parity bit together contain an odd number of ones. With `line_cfg[4]` = 1 they contain an even number.
- R6: When `line_cfg[3]` and `line_cfg[5]` are both 1, the parity bit is fixed. It is 1 when `line_cfg[4]` is 0 and 0 when `line_cfg[4]` is 1.
- R7: The stop level is 1. With `line_cfg[2]` = 0 the stop period lasts 16 ticks. With `line_cfg[2]` = 1 it lasts 32 ticks for 6, 7 or 8 data bits and 24 ticks for 5 data bits.
- R8: If a byte is waiting in the holding register when the last stop tick is consumed, its start bit begins on that same edge, with no idle time between frames. Otherwise the line returns to mark.
- R9: `tx_empty` is 1 only when the holding register and the shift stage are both empty. It is 0 for the whole of every frame.
- R10: While `line_cfg[6]` is 1, `txd` is 0. The break does not stop or stretch the frame in progress.
- R11: `line_cfg[5:0]` are sampled when a byte enters the shift stage. A change during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| line_cfg | input | 7 | Bits 1:0 word length; bit 2 long stop; bit 3 parity on; bit 4 even / fixed-0 select; bit 5 fixed parity; bit 6 break |
| in_valid | input | 1 | Byte offered on `in_data` |
| in_ready | output | 1 | Holding register empty; a byte is taken when this and `in_valid` are both 1 |
| in_data | input | DATA_W | Byte to send; bits above the word length are ignored |
| txd | output | 1 | Serial line output, 1 when idle |
| tx_empty | output | 1 | Holding register and shift stage both empty |

## Verification
The hardest case to reach is the edge where a frame's last stop tick is consumed. At that edge, whether the next start bit follows at once depends on whether a byte was already waiting, or arrives on that very edge. To get there, the stimulus sends bursts pushed as fast as `in_ready` allows, so the holding register is usually full when a frame ends. It also inserts random idle gaps and varies the spacing of the baud ticks, so that some writes land on or near the end edge. The bench records the clock edge at which each byte was taken and uses it to decide whether an immediate restart or an idle line is expected. Every one of the 64 format settings is swept, including the 24-tick stop case, and the frame length is checked by counting ticks between start edges.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Shift stage phase
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_e;

endpackage

// File: rtl/sertx_parity.sv
module sertx_parity #(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        wsel,
  input  logic              stick,
  input  logic              even,
  output logic              par_bit
);
  localparam int CW = $clog2(DATA_W + 1);

  logic [CW-1:0]     nbits;
  logic [DATA_W-1:0] keep;

  assign nbits = CW'(MIN_W) + CW'(wsel);

  // Mask off the bits above the selected word length
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign keep[i] = (CW'(i) < nbits);
  end

  // Fixed level, or a bit that makes the total count of ones odd or even
  assign par_bit = stick ? ~even : ((^(data & keep)) ^ ~even);

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  output logic              in_ready,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign in_ready  = !full_q;
  assign hold_full = full_q;
  assign hold_data = data_q;

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [5:0]        fmt_in,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              line_bit,
  output logic              idle
);
  localparam int TW = $clog2(2 * OS);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [TW-1:0] LAST_1   = TW'(OS - 1);
  localparam logic [TW-1:0] LAST_1H  = TW'(OS + OS / 2 - 1);
  localparam logic [TW-1:0] LAST_2   = TW'(2 * OS - 1);

  phase_e            ph;
  logic [TW-1:0]     tcnt;
  logic [CW-1:0]     bidx;
  logic [DATA_W-1:0] sh;
  logic [1:0]        wsel_q;
  logic              long_q;
  logic              pen_q;
  logic              par_q;

  logic              par_new;
  logic [CW-1:0]     nbits_q;
  logic [TW-1:0]     stop_last;
  logic [TW-1:0]     ph_last;
  logic              bit_end;

  sertx_parity #(.DATA_W(DATA_W), .MIN_W(MIN_W)) u_par (
    .data   (hold_data),
    .wsel   (fmt_in[1:0]),
    .stick  (fmt_in[5]),
    .even   (fmt_in[4]),
    .par_bit(par_new)
  );

  assign nbits_q   = CW'(MIN_W) + CW'(wsel_q);
  assign stop_last = !long_q ? LAST_1 : ((wsel_q == 2'd0) ? LAST_1H : LAST_2);
  assign ph_last   = (ph == PH_STOP) ? stop_last : LAST_1;
  assign bit_end   = baud_tick && (ph != PH_IDLE) && (tcnt == ph_last);
  assign take      = hold_full && ((ph == PH_IDLE) || ((ph == PH_STOP) && bit_end));
  assign idle      = (ph == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      tcnt   <= '0;
      bidx   <= '0;
      sh     <= '0;
      wsel_q <= 2'd0;
      long_q <= 1'b0;
      pen_q  <= 1'b0;
      par_q  <= 1'b0;
    end else if (take) begin
      ph     <= PH_START;
      tcnt   <= '0;
      bidx   <= '0;
      sh     <= hold_data;
      wsel_q <= fmt_in[1:0];
      long_q <= fmt_in[2];
      pen_q  <= fmt_in[3];
      par_q  <= par_new;
    end else if (baud_tick && (ph != PH_IDLE)) begin
      if (tcnt == ph_last) begin
        tcnt <= '0;
        case (ph)
          PH_START: begin
            ph   <= PH_DATA;
            bidx <= '0;
          end
          PH_DATA: begin
            sh <= sh >> 1;
            if (bidx == nbits_q - CW'(1)) ph <= pen_q ? PH_PAR : PH_STOP;
            else                          bidx <= bidx + CW'(1);
          end
          PH_PAR:  ph <= PH_STOP;
          default: ph <= PH_IDLE;
        endcase
      end else begin
        tcnt <= tcnt + TW'(1);
      end
    end
  end

  always_comb begin
    case (ph)
      PH_START: line_bit = 1'b0;
      PH_DATA:  line_bit = sh[0];
      PH_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

endmodule

// File: rtl/framed_serial_tx.sv
module framed_serial_tx #(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [6:0]        line_cfg,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              txd,
  output logic              tx_empty
);
  logic              take;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              line_bit;
  logic              sh_idle;

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .take     (take),
    .in_ready (in_ready),
    .hold_full(hold_full),
    .hold_data(hold_data)
  );

  sertx_shifter #(.DATA_W(DATA_W), .MIN_W(MIN_W), .OS(OS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .baud_tick(baud_tick),
    .fmt_in   (line_cfg[5:0]),
    .hold_full(hold_full),
    .hold_data(hold_data),
    .take     (take),
    .line_bit (line_bit),
    .idle     (sh_idle)
  );

  // Break overrides the line; the frame keeps running underneath
  assign txd      = line_bit & ~line_cfg[6];
  assign tx_empty = sh_idle & ~hold_full;

endmodule

// File: rtl/framed_serial_tx_chk.sv
module framed_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic brk,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic tx_empty
);
  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (txd || brk));

  // R2
  hold_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9
  empty_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> in_ready);

  // R3
  rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !brk) |=> (brk || !$rose(txd)));

  // R9
  write_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !tx_empty);
endmodule

bind framed_serial_tx framed_serial_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .baud_tick(baud_tick),
  .brk      (line_cfg[6]),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .txd      (txd),
  .tx_empty (tx_empty)
);

// File: tb/framed_serial_tx_tb.sv
module framed_serial_tx_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, baud_tick, in_valid, in_ready, txd, tx_empty;
  logic [6:0] line_cfg;
  logic [7:0] in_data;

  framed_serial_tx u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .line_cfg(line_cfg),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .txd(txd), .tx_empty(tx_empty)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  typedef struct {
    logic [7:0] d;
    logic [5:0] cfg;
    int         acc;
  } ent_t;
  ent_t q[$];

  int tick_per = 1;
  int tcount   = 0;
  bit mon_en   = 0;

  initial begin
    baud_tick = 1'b0;
    forever begin
      @(posedge clk); #1;
      baud_tick = (tcount == 0);
      tcount    = (tcount + 1 >= tick_per) ? 0 : tcount + 1;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [7:0] d);
    bit ok;
    in_valid = 1'b1;
    in_data  = d;
    forever begin
      ok = in_ready;
      step();
      if (ok) break;
    end
    in_valid = 1'b0;
    if (mon_en) q.push_back('{d: d, cfg: line_cfg[5:0], acc: cyc});
  endtask

  task automatic wait_idle();
    while (!tx_empty || q.size() != 0) step();
    repeat (2) step();
  endtask

  // Expected frame, computed from the requirements
  bit    exp_b[16];
  string tags[16];
  int    nslots, kticks, idx, end_edge;
  bit    in_frame = 0, endchk = 0, prev_txd = 1;

  task automatic build(input ent_t e);
    int  n, s;
    bit  x;
    n = 5 + int'(e.cfg[1:0]);
    s = 0;
    exp_b[s] = 1'b0; tags[s] = "R3 start bit"; s++;
    x = 1'b0;
    for (int i = 0; i < n; i++) begin
      exp_b[s] = e.d[i]; tags[s] = "R3 data bit"; s++;
      x ^= e.d[i];
    end
    if (e.cfg[3]) begin
      if (e.cfg[5]) begin exp_b[s] = ~e.cfg[4];     tags[s] = "R6 fixed parity"; end
      else          begin exp_b[s] = x ^ ~e.cfg[4]; tags[s] = "R5 parity";       end
      s++;
    end
    exp_b[s] = 1'b1; tags[s] = e.cfg[3] ? "R7 stop" : "R4 stop follows data"; s++;
    if (e.cfg[2] && n > 5) begin exp_b[s] = 1'b1; tags[s] = "R7 second stop"; s++; end
    nslots = s;
    kticks = 16 * (1 + n + int'(e.cfg[3])) + (!e.cfg[2] ? 16 : (n == 5 ? 24 : 32));
  endtask

  always @(negedge clk) begin
    bit   b2b;
    ent_t e;
    if (!mon_en) begin
      in_frame = 0;
      endchk   = 0;
    end else begin
      if (endchk) begin
        endchk = 0;
        b2b = (q.size() > 0) && (q[0].acc < end_edge);
        chk("R8 line after last stop tick", txd, b2b ? 0 : 1);
        if (q.size() == 0) chk("R9 empty after frame", tx_empty, 1);
      end
      if (!in_frame && prev_txd && !txd) begin
        if (q.size() == 0) chk("R3 unexpected start", 1, 0);
        else begin
          e = q.pop_front();
          build(e);
          in_frame = 1;
          idx = 0;
        end
      end
      if (in_frame && baud_tick) begin
        if (idx % 16 == 8 && idx / 16 < nslots) begin
          chk(tags[idx / 16], txd, exp_b[idx / 16]);
          chk("R9 busy during frame", tx_empty, 0);
        end
        if (idx == kticks - 2) chk("R7 stop tail", txd, 1);
        idx++;
        if (idx == kticks) begin
          in_frame = 0;
          endchk   = 1;
          end_edge = cyc + 1;
        end
      end
    end
    prev_txd = txd;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a, bb;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; line_cfg = 7'h03;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 reset txd", txd, 1);
    chk("R1 reset in_ready", in_ready, 1);
    chk("R1 reset tx_empty", tx_empty, 1);

    // R2 / R9 holding and shifter status
    mon_en = 1; tick_per = 2;
    push(8'hA5);
    chk("R2 holding full after write", in_ready, 0);
    chk("R9 not empty after write", tx_empty, 0);
    step();
    chk("R2 holding empty while shifting", in_ready, 1);
    chk("R9 not empty while shifting", tx_empty, 0);
    chk("R3 start bit follows load", txd, 0);
    push(8'h3C);
    chk("R2 second byte waits", in_ready, 0);
    wait_idle();

    // R11 format captured at frame start
    bb = bad;
    line_cfg = 7'h03;
    push(8'h96);
    step();
    line_cfg = 7'h2C;
    wait_idle();
    chk("R11 frame kept captured format", bad, bb);
    line_cfg = 7'h03;

    // R10 break while idle and during a frame
    mon_en = 0; tick_per = 1;
    step();
    line_cfg[6] = 1'b1;
    step();
    chk("R10 break while idle", txd, 0);
    repeat (40) step();
    chk("R10 break held", txd, 0);
    chk("R10 break keeps empty", tx_empty, 1);
    line_cfg[6] = 1'b0;
    step();
    chk("R10 break released", txd, 1);
    push(8'hFF);
    a = cyc;
    repeat (40) step();
    chk("R3 data bit of all-ones byte", txd, 1);
    line_cfg[6] = 1'b1;
    repeat (5) step();
    chk("R10 break inside frame", txd, 0);
    line_cfg[6] = 1'b0;
    step();
    chk("R10 line back after break", txd, 1);
    while (!tx_empty) step();
    chk("R10 frame length unchanged by break", cyc - a, 161);
    repeat (2) step();
    mon_en = 1;

    // Sweep of every format, bursts at one tick per cycle
    for (int c = 0; c < 64; c++) begin
      line_cfg = {1'b0, 6'(c)};
      for (int k = 0; k < 3; k++) push(8'($urandom));
      wait_idle();
    end

    // Random formats, tick spacing and idle gaps
    for (int r = 0; r < 16; r++) begin
      tick_per = 1 + int'($urandom % 4);
      line_cfg = {1'b0, 6'($urandom)};
      for (int k = 0; k < 3; k++) begin
        repeat (int'($urandom % 40)) step();
        push(8'($urandom));
      end
      wait_idle();
    end

    chk("R9 empty at end", tx_empty, 1);
    chk("R1 mark at end", txd, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule